// File: doc/BRIEF.md
# Asynchronous Handshake Bus Read Master

This block runs read cycles on a parallel bus that has separate address and data lines and is closed by the slave rather than by a fixed wait count. A local requester presents an address, a 4-bit function code and an operand size (byte or word) with a valid/ready handshake.

The master then drives the address, function code, size code and read/write line. After one setup clock it pulls the address and data strobes low together. It waits for the slave to drive either of its two active-low acknowledge lines, which reach the control logic only through a two-flop synchroniser. The read data passes through its own de-skew register and is captured one clock after the synchronised acknowledge is seen. The strobes are then released and the requester gets a one-cycle response pulse.

If no acknowledge shows up within a programmable number of clocks, the cycle is abandoned and the response carries an error flag. The next cycle cannot begin until both acknowledge lines have been seen high again.

Top module: `async_bus_rd_master`

## Requirements
- R1: After reset both strobes are high, the read/write line is 1 (read), `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted on a clock edge has `bus_addr`, `bus_fc` and `bus_siz` driven from the next clock on. Both strobes stay high for that one full setup clock.
- R3: Both strobes fall together on the clock after setup. They stay low, with address, function code and size held steady, until the cycle ends.
- R4: `bus_siz` is 2'b01 for a byte read (`req_word`=0) and 2'b10 for a word read (`req_word`=1).
- R5: A word read returns all 16 bus data bits unchanged on `rsp_data`.
- R6: A byte read with address bit 0 clear returns bus bits 15:8 in `rsp_data[7:0]`. With address bit 0 set it returns bus bits 7:0. In both cases `rsp_data[15:8]` is zero.
- R7: An acknowledge is either `bus_dsack_n` bit being low. If it is first driven k clocks after the clock in which the strobes fell, the response appears k+4 clocks after that clock. The strobes are high in the same clock as the response.
- R8: `rsp_valid` is a single-clock pulse, and `rsp_err` is 0 for an acknowledged cycle.
- R9: With no acknowledge, the response appears `timeout_lim`+1 clocks after the strobes fell, with `rsp_err`=1, `rsp_data`=0 and both strobes high.
- R10: When an acknowledge and timeout expiry reach the control logic in the same clock, the acknowledge wins. With k as in R7, k = `timeout_lim`-2 still returns data and k = `timeout_lim`-1 returns an error.
- R11: After a response, `req_ready` stays 0 and the strobes stay high until both acknowledge lines have been high long enough to pass the synchroniser.
- R12: `req_ready` is 1 only when no cycle is running. A `req_valid` presented during a cycle is ignored and leaves the driven address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timeout_lim | input | TOW (16) | Clocks to wait for acknowledge before error |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Master idle, request accepted when valid |
| req_addr | input | AW (32) | Read address |
| req_fc | input | FCW (4) | Function code |
| req_word | input | 1 | 1 = word read, 0 = byte read |
| rsp_valid | output | 1 | One-clock response pulse |
| rsp_data | output | DW (16) | Read data, byte reads right-aligned |
| rsp_err | output | 1 | Cycle ended by timeout |
| bus_addr | output | AW (32) | Address bus |
| bus_fc | output | FCW (4) | Function code lines |
| bus_siz | output | 2 | Operand size code |
| bus_rw | output | 1 | Read/write line, 1 = read |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_dsack_n | input | 2 | Slave acknowledge lines, active low |
| bus_data | input | DW (16) | Data bus from slave |

## Verification
The synchronised acknowledge and the expiry of the timeout counter can arrive in the same clock. Only one of them may end the cycle. The bench provokes this by driving the acknowledge exactly `timeout_lim`-2 and then `timeout_lim`-1 clocks after the strobes fall, which places its synchronised copy on the expiry clock and one clock past it. The first case must return the slave's data with no error, and the second must return zero data with the error flag set.

// File: rtl/abm_pkg.sv
package abm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_WAIT    = 3'd2,
    ST_LATCH   = 3'd3,
    ST_RECOVER = 3'd4
  } abm_state_t;

  localparam logic [1:0] SIZ_BYTE = 2'b01;
  localparam logic [1:0] SIZ_WORD = 2'b10;

  // Byte reads come from the upper lane on even addresses and the
  // lower lane on odd ones, right-aligned in the result.
  function automatic logic [15:0] pick_lane(input logic [15:0] d,
                                            input logic        word,
                                            input logic        a0);
    if (word)     return d;
    else if (!a0) return {8'h00, d[15:8]};
    else          return {8'h00, d[7:0]};
  endfunction

endpackage

// File: rtl/abm_sync.sv
module abm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= INIT;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= INIT;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/abm_timer.sv
module abm_timer #(
  parameter int TOW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           en,
  input  logic [TOW-1:0] lim,
  output logic           expired
);
  logic [TOW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (en && !expired) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == lim);
endmodule

// File: rtl/abm_capture.sv
module abm_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus_data,
  input  logic          word,
  input  logic          a0,
  output logic [DW-1:0] lane_data
);
  import abm_pkg::*;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= bus_data;
  end

  assign lane_data = pick_lane(data_q, word, a0);
endmodule

// File: rtl/async_bus_rd_master.sv
module async_bus_rd_master #(
  parameter int AW  = 32,
  parameter int FCW = 4,
  parameter int DW  = 16,
  parameter int TOW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [TOW-1:0] timeout_lim,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [FCW-1:0] req_fc,
  input  logic           req_word,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_data,
  output logic           rsp_err,
  output logic [AW-1:0]  bus_addr,
  output logic [FCW-1:0] bus_fc,
  output logic [1:0]     bus_siz,
  output logic           bus_rw,
  output logic           bus_as_n,
  output logic           bus_ds_n,
  input  logic [1:0]     bus_dsack_n,
  input  logic [DW-1:0]  bus_data
);
  import abm_pkg::*;

  abm_state_t state;
  logic [1:0] ack_s;
  logic       ack_seen;
  logic       expired;
  logic       word_q;
  logic [DW-1:0] lane_data;

  abm_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b00)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (~bus_dsack_n),
    .q   (ack_s)
  );

  assign ack_seen = |ack_s;

  abm_timer #(.TOW(TOW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (state == ST_SETUP),
    .en      (state == ST_WAIT),
    .lim     (timeout_lim),
    .expired (expired)
  );

  abm_capture #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .bus_data  (bus_data),
    .word      (word_q),
    .a0        (bus_addr[0]),
    .lane_data (lane_data)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_addr  <= '0;
      bus_fc    <= '0;
      bus_siz   <= SIZ_BYTE;
      bus_rw    <= 1'b1;
      bus_as_n  <= 1'b1;
      bus_ds_n  <= 1'b1;
      word_q    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      bus_rw    <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            bus_addr <= req_addr;
            bus_fc   <= req_fc;
            bus_siz  <= req_word ? SIZ_WORD : SIZ_BYTE;
            word_q   <= req_word;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          bus_as_n <= 1'b0;
          bus_ds_n <= 1'b0;
          state    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ack_seen) begin
            state <= ST_LATCH;
          end else if (expired) begin
            bus_as_n  <= 1'b1;
            bus_ds_n  <= 1'b1;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_data  <= '0;
            state     <= ST_RECOVER;
          end
        end
        ST_LATCH: begin
          bus_as_n  <= 1'b1;
          bus_ds_n  <= 1'b1;
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b0;
          rsp_data  <= lane_data;
          state     <= ST_RECOVER;
        end
        ST_RECOVER: begin
          if (!ack_seen) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abm_checker.sv
module abm_checker #(
  parameter int AW  = 32,
  parameter int FCW = 4,
  parameter int DW  = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           rsp_err,
  input logic [DW-1:0]  rsp_data,
  input logic [AW-1:0]  bus_addr,
  input logic [FCW-1:0] bus_fc,
  input logic [1:0]     bus_siz,
  input logic           bus_as_n,
  input logic           bus_ds_n
);
  // R3
  strobes_together_chk: assert property (@(posedge clk) disable iff (rst)
    bus_as_n == bus_ds_n);

  // R2
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_as_n) |-> ($stable(bus_addr) && $stable(bus_fc) && $stable(bus_siz)));

  // R3
  addr_held_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_as_n && !$past(bus_as_n)) |-> ($stable(bus_addr) && $stable(bus_fc)));

  // R4
  siz_code_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_as_n |-> (bus_siz == 2'b01 || bus_siz == 2'b10));

  // R7
  strobe_off_at_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> bus_as_n);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9
  err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

  // R12
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> bus_as_n);
endmodule

bind async_bus_rd_master abm_checker #(.AW(AW), .FCW(FCW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data),
  .bus_addr  (bus_addr),
  .bus_fc    (bus_fc),
  .bus_siz   (bus_siz),
  .bus_as_n  (bus_as_n),
  .bus_ds_n  (bus_ds_n)
);

// File: tb/async_bus_rd_master_tb.sv
`timescale 1ns/1ps
module async_bus_rd_master_tb_top;
  localparam int LIM = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] timeout_lim = 16'(LIM);
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_fc = '0;
  logic        req_word = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        rsp_err;
  logic [31:0] bus_addr;
  logic [3:0]  bus_fc;
  logic [1:0]  bus_siz;
  logic        bus_rw;
  logic        bus_as_n;
  logic        bus_ds_n;
  logic [1:0]  bus_dsack_n = 2'b11;
  logic [15:0] bus_data = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  async_bus_rd_master dut_i (
    .clk(clk), .rst(rst), .timeout_lim(timeout_lim),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_fc(req_fc), .req_word(req_word),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_siz(bus_siz), .bus_rw(bus_rw),
    .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
    .bus_dsack_n(bus_dsack_n), .bus_data(bus_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // k < 0: the slave never acknowledges. poke: try a second request mid-cycle.
  task automatic run_read(input logic [31:0] a, input logic [3:0] fc,
                          input bit word, input int k, input logic [15:0] d,
                          input bit poke, output logic [15:0] rd,
                          output bit er, output int lat);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_fc = fc; req_word = word;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_addr == a, "R2 addr", bus_addr, a);
    chk(bus_fc == fc, "R2 fc", 32'(bus_fc), 32'(fc));
    chk(bus_as_n && bus_ds_n, "R2 strobes high in setup", 32'({bus_as_n, bus_ds_n}), 32'h3);
    chk(bus_siz == (word ? 2'b10 : 2'b01), "R4 siz", 32'(bus_siz), word ? 32'h2 : 32'h1);
    @(negedge clk);
    chk(!bus_as_n && !bus_ds_n, "R3 strobes low", 32'({bus_as_n, bus_ds_n}), 32'h0);
    n = 0;
    if (k == 0) begin bus_dsack_n = 2'b00; bus_data = d; end
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
      if (n == k) begin bus_dsack_n = word ? 2'b00 : 2'b10; bus_data = d; end
      if (poke && n == 1) begin
        req_valid = 1'b1; req_addr = ~a;
        chk(!req_ready, "R12 busy not ready", 32'(req_ready), 32'h0);
      end
      if (poke && n == 2) begin
        chk(bus_addr == a, "R12 addr unchanged", bus_addr, a);
        req_valid = 1'b0;
      end
    end
    rd = rsp_data; er = rsp_err; lat = n;
    chk(bus_as_n && bus_ds_n, "R7 strobes high at response", 32'({bus_as_n, bus_ds_n}), 32'h3);
  endtask

  task automatic release_ack();
    int w;
    bus_dsack_n = 2'b11;
    w = 0;
    while (!req_ready && w < 20) begin @(negedge clk); w++; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bus_as_n && bus_ds_n, "R1 strobes", 32'({bus_as_n, bus_ds_n}), 32'h3);
    chk(bus_rw == 1'b1, "R1 rw", 32'(bus_rw), 32'h1);
    chk(!rsp_valid, "R1 rsp_valid", 32'(rsp_valid), 32'h0);
    chk(req_ready, "R1 ready", 32'(req_ready), 32'h1);
  endtask

  task automatic t_word();
    logic [15:0] rd; bit er; int lat;
    run_read(32'h0000_1000, 4'h5, 1'b1, 2, 16'hA55A, 1'b0, rd, er, lat);
    chk(rd == 16'hA55A, "R5 word data", 32'(rd), 32'hA55A);
    chk(!er, "R8 no error", 32'(er), 32'h0);
    chk(lat == 6, "R7 latency", 32'(lat), 32'd6);
    @(negedge clk);
    chk(!rsp_valid, "R8 single pulse", 32'(rsp_valid), 32'h0);
    release_ack();
    run_read(32'h0000_2222, 4'h9, 1'b1, 0, 16'h1234, 1'b0, rd, er, lat);
    chk(rd == 16'h1234 && lat == 4, "R7 immediate ack", {rd, 16'(lat)}, 32'h1234_0004);
    release_ack();
  endtask

  task automatic t_byte();
    logic [15:0] rd; bit er; int lat;
    run_read(32'h0000_0010, 4'h1, 1'b0, 1, 16'hC3E7, 1'b0, rd, er, lat);
    chk(rd == 16'h00C3, "R6 even byte", 32'(rd), 32'h00C3);
    release_ack();
    run_read(32'h0000_0011, 4'h1, 1'b0, 3, 16'hC3E7, 1'b0, rd, er, lat);
    chk(rd == 16'h00E7, "R6 odd byte", 32'(rd), 32'h00E7);
    release_ack();
  endtask

  task automatic t_busy();
    logic [15:0] rd; bit er; int lat;
    run_read(32'h0000_4444, 4'h2, 1'b1, 4, 16'h0F0F, 1'b1, rd, er, lat);
    chk(rd == 16'h0F0F, "R12 first cycle data", 32'(rd), 32'h0F0F);
    release_ack();
    chk(req_ready, "R12 idle after", 32'(req_ready), 32'h1);
  endtask

  task automatic t_timeout();
    logic [15:0] rd; bit er; int lat;
    bus_data = 16'hFFFF;
    run_read(32'h0000_5000, 4'h3, 1'b1, -1, 16'hFFFF, 1'b0, rd, er, lat);
    chk(er, "R9 error flag", 32'(er), 32'h1);
    chk(rd == 16'h0, "R9 zero data", 32'(rd), 32'h0);
    chk(lat == LIM + 1, "R9 timeout latency", 32'(lat), 32'(LIM + 1));
    release_ack();
  endtask

  task automatic t_race();
    logic [15:0] rd; bit er; int lat;
    run_read(32'h0000_6000, 4'h4, 1'b1, LIM - 2, 16'hBEEF, 1'b0, rd, er, lat);
    chk(!er && rd == 16'hBEEF, "R10 ack wins on expiry clock", {15'(0), er, rd}, 32'h0000_BEEF);
    release_ack();
    run_read(32'h0000_6002, 4'h4, 1'b1, LIM - 1, 16'hBEEF, 1'b0, rd, er, lat);
    chk(er && rd == 16'h0, "R10 late ack loses", {15'(0), er, rd}, 32'h0001_0000);
    release_ack();
  endtask

  task automatic t_recover();
    logic [15:0] rd; bit er; int lat;
    int w;
    bit held_ok;
    run_read(32'h0000_7000, 4'h6, 1'b1, 1, 16'h7777, 1'b0, rd, er, lat);
    req_valid = 1'b1; req_addr = 32'h0000_7100;
    held_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (req_ready || !bus_as_n) held_ok = 1'b0;
    end
    chk(held_ok, "R11 held while ack low", 32'(held_ok), 32'h1);
    req_valid = 1'b0;
    bus_dsack_n = 2'b11;
    w = 0;
    while (!req_ready && w < 10) begin @(negedge clk); w++; end
    chk(req_ready, "R11 ready after release", 32'(req_ready), 32'h1);
    chk(w >= 2, "R11 release passes synchroniser", 32'(w), 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_word();
    t_byte();
    t_busy();
    t_timeout();
    t_race();
    t_recover();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule